// File: doc/BRIEF.md
# Multi-Mode Compare Timer Core

This block is a 24-bit up counter paced by an 8-bit prescaler. While enabled, the counter advances by one every `div + 1` clock cycles. The count is compared against a programmable compare value. A match sets a sticky timer flag, and the flag raises the interrupt line when interrupts are enabled. Software clears the flag by writing a one to it.

Four operating modes set what happens at a match. One-shot stops the timer. Periodic reloads the count to zero. Toggle reloads the count and also inverts a square-wave output. Continuous counting lets the count run on past the match.

A write to the compare value may restart the counter, depending on the mode and a keep-running control bit. A reset request stops an active timer and clears its count. The control fields are loaded together through one write strobe. The compare value has its own strobe. Compare values of 0 and 1 are not supported.

Top module: `tmr_core`

## Requirements
- R1: After reset, `count` is 0 and `active`, `tmr_flag`, `tmr_irq` and `tog_out` are all 0.
- R2: While the timer is enabled, `count` increments once every `div + 1` clock cycles and wraps modulo 2^24. While it is disabled, `count` holds its value.
- R3: In one-shot mode (`ctl_mode` = 2'b00), the timer disables itself at a match. From the next cycle `active` is 0 and `count` stays at the compare value.
- R4: In periodic mode (2'b01) and in toggle mode, `count` returns to 0 and the prescaler restarts on the cycle after a match.
- R5: `tmr_flag` is set on the edge where `count` reaches the compare value. It stays set until a `flag_clr` pulse clears it.
- R6: In toggle mode (2'b10), `tog_out` inverts at every match. It never changes in the other modes.
- R7: `tmr_irq` is high exactly when `tmr_flag` is set and the interrupt-enable field is 1.
- R8: In continuous mode (2'b11), a match sets `tmr_flag` but does not reload `count`, which keeps incrementing past the compare value.
- R9: A `rst_req` pulse while `active` is 1 clears the prescaler, `count` and the enable bit. While `active` is 0 the pulse has no effect and `count` keeps its value.
- R10: In one-shot, periodic or toggle mode with the keep bit at 0, a compare write clears `count` and the prescaler.
- R11: In those modes with the keep bit at 1, a compare write leaves `count` running. The exception is a new value equal to the current count, which clears `count`.
- R12: In continuous mode, a compare write never clears `count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Loads all control fields below |
| ctl_enable | input | 1 | Enable bit value |
| ctl_mode | input | 2 | Mode: 00 one-shot, 01 periodic, 10 toggle, 11 continuous |
| ctl_int_en | input | 1 | Interrupt enable |
| ctl_cmp_keep | input | 1 | 1: a compare write keeps the counter running |
| ctl_div | input | 8 | Prescale divisor minus one |
| rst_req | input | 1 | Counter reset request pulse |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_wdata | input | 24 | New compare value |
| flag_clr | input | 1 | Write-one-to-clear pulse for the flag |
| count | output | 24 | Live counter value |
| active | output | 1 | Timer enabled and counting |
| tmr_flag | output | 1 | Sticky match flag |
| tmr_irq | output | 1 | Interrupt line |
| tog_out | output | 1 | Toggle-mode square wave |

## Verification
Every input strobe takes effect on the next rising edge. The effects of a write, a reset request or a prescaler tick (a count step, a restart, the flag, the toggle and the stop) appear at the outputs one cycle after the inputs are driven. A match reload lands one further cycle after the match. Inputs change on falling edges, and both the reference model and the directed checks read the outputs on falling edges. That places every comparison half a cycle after the edge that produced it. The directed checks for prescaler pacing, the toggle count and the compare-write corner cases are placed by counting edges from the write that started each scenario.

// File: rtl/tmr_core_pkg.sv
// Shared types for the compare timer core.
// Assumes: the mode encoding below is the one seen on the control port.
package tmr_core_pkg;

    typedef enum logic [1:0] {
        MODE_ONESHOT  = 2'b00,
        MODE_PERIODIC = 2'b01,
        MODE_TOGGLE   = 2'b10,
        MODE_FREERUN  = 2'b11
    } tmr_mode_e;

endpackage

// File: rtl/tmr_prescale.sv
// Prescaler: emits a one-cycle tick every DIV+1 cycles while running.
// Assumes: clear has priority and restarts the phase at zero.
module tmr_prescale #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [PSC_W-1:0] div,
    output logic             tick
);

    logic [PSC_W-1:0] phase_q;
    logic             at_end;

    assign at_end = (phase_q == div);
    assign tick   = run && !clear && at_end;

    // Advance the divider phase, wrapping at the programmed divisor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clear) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= at_end ? '0 : phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_counter.sv
// Up counter with match detection and a one-cycle delayed reload.
// Assumes: tick is already suppressed during clear and reload cycles.
module tmr_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear_now,
    input  logic             reload_mode,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] count,
    output logic             wrap_pend,
    output logic             hit
);

    logic [CNT_W-1:0] count_inc;

    assign count_inc = count + 1'b1;
    assign hit       = tick && (count_inc == cmp);

    // Hold, step, clear or reload the count value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear_now || wrap_pend) begin
            count <= '0;
        end else if (tick) begin
            count <= count_inc;
        end
    end

    // Remember a reloading match so the count returns to zero next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap_pend <= 1'b0;
        end else begin
            wrap_pend <= !clear_now && hit && reload_mode;
        end
    end

endmodule

// File: rtl/tmr_events.sv
// Match consequences: sticky flag, interrupt gating and toggle output.
// Assumes: a match in the same cycle as a clear keeps the flag set.
module tmr_events (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic toggle_mode,
    input  logic flag_clr,
    input  logic int_en,
    output logic flag,
    output logic irq,
    output logic tog
);

    assign irq = flag && int_en;

    // Set the flag on a match, drop it on a write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

    // Invert the square wave on each match in toggle mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog <= 1'b0;
        end else if (hit && toggle_mode) begin
            tog <= ~tog;
        end
    end

endmodule

// File: rtl/tmr_core.sv
// Top of the compare timer: control fields, compare value, enable bit and
// restart arbitration around the prescaler, counter and event logic.
// Assumes: compare values 0 and 1 are never programmed; strobes are
// single-cycle pulses in the clk domain.
module tmr_core
    import tmr_core_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             ctl_enable,
    input  logic [1:0]       ctl_mode,
    input  logic             ctl_int_en,
    input  logic             ctl_cmp_keep,
    input  logic [PSC_W-1:0] ctl_div,
    input  logic             rst_req,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             active,
    output logic             tmr_flag,
    output logic             tmr_irq,
    output logic             tog_out
);

    tmr_mode_e        mode_q;
    logic             en_q;
    logic             int_en_q;
    logic             keep_q;
    logic [PSC_W-1:0] div_q;
    logic [CNT_W-1:0] cmp_q;

    logic             rst_hit;
    logic             cmp_restart;
    logic             clear_now;
    logic             wrap_pend;
    logic             tick;
    logic             hit;
    logic             reload_mode;
    logic             oneshot_done;

    assign rst_hit      = rst_req && en_q;
    assign cmp_restart  = cmp_we && !rst_hit && (mode_q != MODE_FREERUN)
                          && (!keep_q || (cmp_wdata == count));
    assign clear_now    = rst_hit || cmp_restart;
    assign reload_mode  = (mode_q == MODE_PERIODIC) || (mode_q == MODE_TOGGLE);
    assign oneshot_done = hit && (mode_q == MODE_ONESHOT);
    assign active       = en_q;

    // Load the static control fields on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_ONESHOT;
            int_en_q <= 1'b0;
            keep_q   <= 1'b0;
            div_q    <= '0;
        end else if (ctl_we) begin
            mode_q   <= tmr_mode_e'(ctl_mode);
            int_en_q <= ctl_int_en;
            keep_q   <= ctl_cmp_keep;
            div_q    <= ctl_div;
        end
    end

    // Enable bit: software write, cleared by a one-shot match or a reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (rst_hit || oneshot_done) begin
            en_q <= 1'b0;
        end else if (ctl_we) begin
            en_q <= ctl_enable;
        end
    end

    // Capture a newly written compare value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (cmp_we) begin
            cmp_q <= cmp_wdata;
        end
    end

    tmr_prescale #(.PSC_W(PSC_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (en_q),
        .clear (clear_now || wrap_pend),
        .div   (div_q),
        .tick  (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .clear_now   (clear_now),
        .reload_mode (reload_mode),
        .cmp         (cmp_q),
        .count       (count),
        .wrap_pend   (wrap_pend),
        .hit         (hit)
    );

    tmr_events u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit         (hit),
        .toggle_mode (mode_q == MODE_TOGGLE),
        .flag_clr    (flag_clr),
        .int_en      (int_en_q),
        .flag        (tmr_flag),
        .irq         (tmr_irq),
        .tog         (tog_out)
    );

endmodule

// File: rtl/tmr_core_chk.sv
// Protocol checker for tmr_core, attached through bind.
// Assumes: mode uses the package encoding; hit is the internal match pulse.
module tmr_core_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic             hit,
    input logic             flag_clr,
    input logic [CNT_W-1:0] count,
    input logic             active,
    input logic             tmr_flag,
    input logic             tog_out
);

    // R2: the count only ever steps by one or drops to zero.
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count) |-> ((count == $past(count) + 1'b1) || (count == '0)));

    // R3: a one-shot match stops the timer.
    p_oneshot_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (mode == 2'b00)) |=> !active);

    // R4: a reloading match leaves the count at zero two edges later.
    p_reload_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ((mode == 2'b01) || (mode == 2'b10))) |-> ##2 (count == '0));

    // R5: the flag stays set until a clear pulse arrives.
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_flag && !flag_clr) |=> tmr_flag);

    // R6: the toggle output only moves after a match.
    p_tog_on_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tog_out) |-> $past(hit));

endmodule

bind tmr_core tmr_core_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_q),
    .hit      (hit),
    .flag_clr (flag_clr),
    .count    (count),
    .active   (active),
    .tmr_flag (tmr_flag),
    .tog_out  (tog_out)
);

// File: tb/tmr_core_tb_top.sv
`timescale 1ns/1ps
module tmr_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctl_we, ctl_enable, ctl_int_en, ctl_cmp_keep;
    logic [1:0]  ctl_mode;
    logic [7:0]  ctl_div;
    logic        rst_req, cmp_we, flag_clr;
    logic [23:0] cmp_wdata;
    logic [23:0] count;
    logic        active, tmr_flag, tmr_irq, tog_out;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    tmr_core dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_enable(ctl_enable),
        .ctl_mode(ctl_mode), .ctl_int_en(ctl_int_en), .ctl_cmp_keep(ctl_cmp_keep),
        .ctl_div(ctl_div), .rst_req(rst_req), .cmp_we(cmp_we),
        .cmp_wdata(cmp_wdata), .flag_clr(flag_clr), .count(count),
        .active(active), .tmr_flag(tmr_flag), .tmr_irq(tmr_irq), .tog_out(tog_out)
    );

    // Behavioural reference model, advanced on every rising edge.
    int m_en, m_mode, m_ie, m_keep, m_div, m_psc, m_cnt, m_cmp, m_wrap, m_flag, m_tog;
    int stop_now, restart, tk, matched, old_mode;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_mode = 0; m_ie = 0; m_keep = 0; m_div = 0; m_psc = 0;
            m_cnt = 0; m_cmp = 0; m_wrap = 0; m_flag = 0; m_tog = 0;
        end else begin
            stop_now = (rst_req && m_en != 0) ? 1 : 0;
            restart  = (cmp_we && stop_now == 0 && m_mode != 3 &&
                        (m_keep == 0 || int'(cmp_wdata) == m_cnt)) ? 1 : 0;
            tk       = (m_en != 0 && stop_now == 0 && restart == 0 &&
                        m_wrap == 0 && m_psc == m_div) ? 1 : 0;
            matched  = (tk != 0 && ((m_cnt + 1) % 16777216) == m_cmp) ? 1 : 0;
            old_mode = m_mode;
            if (cmp_we) m_cmp = int'(cmp_wdata);
            if (stop_now != 0 || restart != 0 || m_wrap != 0) begin
                m_cnt = 0; m_psc = 0; m_wrap = 0;
            end else if (m_en != 0) begin
                if (tk != 0) begin m_cnt = (m_cnt + 1) % 16777216; m_psc = 0; end
                else m_psc = m_psc + 1;
            end
            if (matched != 0 && (old_mode == 1 || old_mode == 2)) m_wrap = 1;
            if (matched != 0 && old_mode == 2) m_tog = 1 - m_tog;
            if (matched != 0) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            if (ctl_we) begin
                m_en = int'(ctl_enable); m_mode = int'(ctl_mode); m_ie = int'(ctl_int_en);
                m_keep = int'(ctl_cmp_keep); m_div = int'(ctl_div);
            end
            if (matched != 0 && old_mode == 0) m_en = 0;
            if (stop_now != 0) m_en = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare every output with the model half a cycle after each edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(count) == m_cnt, "R2", "model count", int'(count), m_cnt);
            chk(int'(active) == m_en, "R3", "model active", int'(active), m_en);
            chk(int'(tmr_flag) == m_flag, "R5", "model flag", int'(tmr_flag), m_flag);
            chk(int'(tog_out) == m_tog, "R6", "model toggle", int'(tog_out), m_tog);
            chk(int'(tmr_irq) == (m_flag & m_ie), "R7", "model irq",
                int'(tmr_irq), m_flag & m_ie);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctl(input bit en, input logic [1:0] md, input bit ie,
                       input bit keep, input logic [7:0] dv);
        ctl_we = 1'b1; ctl_enable = en; ctl_mode = md; ctl_int_en = ie;
        ctl_cmp_keep = keep; ctl_div = dv;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wr_cmp(input logic [23:0] v);
        cmp_we = 1'b1; cmp_wdata = v;
        @(negedge clk);
        cmp_we = 1'b0;
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic pulse_rst();
        rst_req = 1'b1;
        @(negedge clk);
        rst_req = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL R2 watchdog: actual 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int togs;
        logic prev;
        rst_n = 1'b0; ctl_we = 0; ctl_enable = 0; ctl_mode = 0; ctl_int_en = 0;
        ctl_cmp_keep = 0; ctl_div = 0; rst_req = 0; cmp_we = 0; cmp_wdata = 0;
        flag_clr = 0;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1: reset state
        chk(count == 0 && !active && !tmr_flag && !tmr_irq && !tog_out,
            "R1", "reset outputs", int'(count), 0);

        // Periodic, divisor 0, compare 4
        wr_cmp(24'd4);
        ctl(1'b1, 2'b01, 1'b1, 1'b0, 8'd0);
        step(4);
        chk(count == 4, "R5", "count at match", int'(count), 4);
        chk(tmr_flag == 1'b1, "R5", "flag at match", int'(tmr_flag), 1);
        chk(tmr_irq == 1'b1, "R7", "irq with enable", int'(tmr_irq), 1);
        step(1);
        chk(count == 0, "R4", "periodic reload", int'(count), 0);
        pulse_clr();
        chk(tmr_flag == 1'b0, "R5", "flag cleared", int'(tmr_flag), 0);

        // Toggle, divisor 1, compare 3, interrupts off
        ctl(1'b0, 2'b01, 1'b1, 1'b0, 8'd0);
        pulse_clr();
        wr_cmp(24'd3);
        ctl(1'b1, 2'b10, 1'b0, 1'b0, 8'd1);
        togs = 0;
        prev = tog_out;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tog_out != prev) togs++;
            prev = tog_out;
            if (i == 3) chk(count == 2, "R2", "prescaled count", int'(count), 2);
        end
        chk(togs == 5, "R6", "toggle edges in window", togs, 5);
        chk(tmr_flag && !tmr_irq, "R7", "irq masked", int'(tmr_irq), 0);

        // One-shot, compare 3
        ctl(1'b0, 2'b10, 1'b0, 1'b0, 8'd1);
        pulse_clr();
        wr_cmp(24'd3);
        chk(count == 0, "R10", "restart on compare write", int'(count), 0);
        ctl(1'b1, 2'b00, 1'b0, 1'b0, 8'd0);
        step(3);
        chk(count == 3 && !active && tmr_flag, "R3", "one-shot stop", int'(active), 0);
        step(5);
        chk(count == 3 && !active, "R3", "one-shot hold", int'(count), 3);

        // Continuous, compare 5
        ctl(1'b0, 2'b00, 1'b0, 1'b0, 8'd0);
        pulse_clr();
        wr_cmp(24'd5);
        ctl(1'b1, 2'b11, 1'b1, 1'b0, 8'd0);
        step(5);
        chk(count == 5 && tmr_flag, "R8", "continuous match", int'(count), 5);
        step(1);
        chk(count == 6, "R8", "count past match", int'(count), 6);
        wr_cmp(24'd2);
        chk(count == 7, "R12", "no restart in continuous", int'(count), 7);
        ctl(1'b0, 2'b11, 1'b1, 1'b0, 8'd0);
        step(3);
        chk(count == 8 && !active, "R2", "hold while disabled", int'(count), 8);

        // Keep-running compare writes in periodic mode
        ctl(1'b0, 2'b01, 1'b1, 1'b1, 8'd0);
        wr_cmp(24'd100);
        pulse_rst();
        chk(count == 8, "R9", "reset request ignored when idle", int'(count), 8);
        ctl(1'b1, 2'b01, 1'b1, 1'b1, 8'd0);
        step(3);
        wr_cmp(24'd200);
        chk(count == 12, "R11", "keep running on write", int'(count), 12);
        wr_cmp(24'd12);
        chk(count == 0, "R11", "restart on equal value", int'(count), 0);
        ctl(1'b1, 2'b01, 1'b1, 1'b0, 8'd0);
        step(3);
        wr_cmp(24'd50);
        chk(count == 0, "R10", "restart with keep off", int'(count), 0);
        step(4);
        chk(count == 4 && active, "R9", "running before reset", int'(count), 4);
        pulse_rst();
        chk(count == 0 && !active, "R9", "reset request stops", int'(count), 0);

        step(2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule